// File: doc/BRIEF.md
# Four-Lane Complex Despreading ALU

This block is a four-lane complex datapath that correlates or despreads a stream of complex samples. Every lane multiplies each sample by a factor drawn from {0, ±1, ±i, ±1±i}. It has no real multiplier: the factor is applied by swapping the real and imaginary parts, negating them and summing the terms. Each lane then adds the result into its own wide complex accumulator. One start command fixes the run: the number of samples, where the lane factors come from, and whether the accumulators start from zero or carry on from their previous contents.

The lane factors can come from three places. The first is a per-lane field latched from the start command. The second is a two-bit scrambling code shared by all lanes. The third is a per-lane spreading-code bit. A fourth mode chains the scrambling code and the spreading bits, so that each lane despreads the same descrambled sample with its own code. The code generators sit outside the block and feed it through input ports. A small controller counts the samples and raises done once the sums are final. The outputs are the accumulator values, saturated symmetrically to the sample width.

Top module: `quad_despread_alu`

## Requirements
- R1: Four lanes run side by side. Each has its own accumulator and its own factor, and lane k drives bits [16k+15:16k] of `out_re` and `out_im`.
- R2: When `start_mode` is 00, the factor of lane k is taken from `start_fac[4k+3:4k]`, which is latched at start. Bits [1:0] give the real coefficient and bits [3:2] give the imaginary coefficient. Each 2-bit code reads 01 as +1, 11 as -1, and 00 or 10 as 0.
- R3: When `start_mode` is 01, every lane uses the factor s_re + i·s_im. Here `scr_code[0]`=1 makes s_re equal -1, otherwise +1, and `scr_code[1]` sets s_im the same way.
- R4: When `start_mode` is 10, lane k uses the factor +1 if `ovsf_code[k]` is 0 and -1 if it is 1.
- R5: When `start_mode` is 11, lane k uses the mode-01 factor multiplied by its mode-10 sign.
- R6: For a sample x+iy and factor a+ib, the lane adds (a·x − b·y) to its real accumulator and (a·y + b·x) to its imaginary accumulator. These sums are exact even for the input -32768.
- R7: The accumulators are 24-bit two's complement and wrap modulo 2^24. They reset to zero. An accepted start with `start_clr`=1 zeroes them, and one with `start_clr`=0 keeps accumulating on top of the old values.
- R8: Each output is its accumulator clamped to the range [-32767, +32767].
- R9: A start with a nonzero `start_len` that arrives while idle raises `busy` from the next cycle. Exactly `start_len` samples are then taken, each on a cycle where `in_valid` is high, and `busy` stays high until the last of them has been accumulated.
- R10: `done` is a one-cycle pulse two clock edges after the last sample is taken. In that cycle `busy` is low and the outputs already hold the final sums.
- R11: A start that arrives while `busy` is high, or that carries `start_len`=0, has no effect on the outputs, on `busy` or on `done`.
- R12: While idle, `in_valid` and the sample and code inputs do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command strobe |
| start_len | input | 8 | Number of samples in the run |
| start_mode | input | 2 | Factor source: 00 field, 01 scrambling, 10 spreading, 11 both |
| start_clr | input | 1 | Zero the accumulators at start |
| start_fac | input | 16 | Per-lane static factor field, 4 bits per lane |
| in_valid | input | 1 | Sample strobe |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| scr_code | input | 2 | Scrambling-code sign bits for this sample |
| ovsf_code | input | 4 | Spreading-code bit per lane for this sample |
| busy | output | 1 | Run in progress, including the last accumulation |
| done | output | 1 | One-cycle pulse when the sums are final |
| out_re | output | 64 | Saturated real sums, 16 bits per lane |
| out_im | output | 64 | Saturated imaginary sums, 16 bits per lane |

## Verification
Directed runs load ±1 and ±i into different lanes in field mode. This separates the swap from the negation and shows that each lane keeps its own accumulator. Runs of the all-negative extreme sample with the four ±1±i factors show whether any product overflows. Long runs of full-scale samples drive both the symmetric clamp and the 24-bit wrap, and the wrap turns a positive sum negative, which a design without the wrap could not produce. Random runs in all four source modes, with random gaps in `in_valid`, random lengths and chained runs with no clear, tell the modes apart. Further stimulus pokes starts while busy, issues zero-length starts and drives sample traffic while idle, to show that each of these is ignored.

// File: rtl/qdsp_pkg.sv
// Package: shared constants and the factor-source encoding for the
// four-lane despreading ALU. Assumes 2-bit signed coefficient codes.
package qdsp_pkg;
    localparam int QD_LANES = 4;   // parallel complex lanes
    localparam int QD_DW    = 16;  // sample width per component
    localparam int QD_GW    = 8;   // accumulator guard bits
    localparam int QD_LW    = 8;   // run-length field width
    localparam int QD_FW    = 4;   // per-lane static factor field width

    // Where the lane factors come from during a run.
    typedef enum logic [1:0] {
        SRC_FIELD    = 2'b00,
        SRC_SCRAMBLE = 2'b01,
        SRC_SPREAD   = 2'b10,
        SRC_CHAINED  = 2'b11
    } src_e;

    // Coefficient codes: 01 is +1, 11 is -1, anything else is 0.
    localparam logic [1:0] COEF_POS = 2'b01;
    localparam logic [1:0] COEF_NEG = 2'b11;
endpackage

// File: rtl/qdsp_opreg.sv
// Module: enable-gated holding register. Used for operand masking (the
// sample operands change only when a sample is taken) and for run
// configuration. Assumes a synchronous active-low reset to zero.
module qdsp_opreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on enable, otherwise hold so that downstream logic stays quiet.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/qdsp_ctrl.sv
// Module: vector controller. Accepts a start command when idle and the
// length is nonzero, counts the samples taken, and marks the accumulate
// stage and the done pulse. Assumes a lane accumulates one cycle after
// its sample is taken.
module qdsp_ctrl #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    input  logic          in_valid,
    output logic          start_ok,
    output logic          take,
    output logic          acc_en,
    output logic          busy,
    output logic          done
);
    logic          run_q;
    logic [LW-1:0] left_q;
    logic          last_q;
    logic          last_hit;

    // Command acceptance, sample acceptance and last-sample detection.
    always_comb begin
        start_ok = start && !busy && (start_len != '0);
        take     = run_q && in_valid;
        last_hit = take && (left_q == LW'(1));
        busy     = run_q || acc_en;
    end

    // Run flag and remaining-sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            left_q <= '0;
        end else if (start_ok) begin
            run_q  <= 1'b1;
            left_q <= start_len;
        end else if (take) begin
            left_q <= left_q - LW'(1);
            if (last_hit) run_q <= 1'b0;
        end
    end

    // Accumulate-stage valid and the done pulse after the final accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_en <= 1'b0;
            last_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            acc_en <= take;
            last_q <= last_hit;
            done   <= last_q;
        end
    end
endmodule

// File: rtl/qdsp_factor_sel.sv
// Module: per-lane factor selection. Turns the run's source mode, the
// lane's static field, the scrambling sign pair and the lane's spreading
// bit into a pair of coefficient codes {imag, real}.
module qdsp_factor_sel
    import qdsp_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [3:0] field,
    input  logic [1:0] scr,
    input  logic       spread,
    output logic [3:0] fac
);
    // Pick the coefficient pair for the selected source.
    always_comb begin
        unique case (src_e'(mode))
            SRC_FIELD:    fac = field;
            SRC_SCRAMBLE: fac = {scr[1] ? COEF_NEG : COEF_POS,
                                 scr[0] ? COEF_NEG : COEF_POS};
            SRC_SPREAD:   fac = {2'b00, spread ? COEF_NEG : COEF_POS};
            default:      fac = {(scr[1] ^ spread) ? COEF_NEG : COEF_POS,
                                 (scr[0] ^ spread) ? COEF_NEG : COEF_POS};
        endcase
    end
endmodule

// File: rtl/qdsp_lane.sv
// Module: one complex lane. A short multiplier applies a + ib with
// a, b in {0, +1, -1} by negating and swapping, and never multiplies.
// A guarded complex accumulator follows, with a symmetric clamp on read.
module qdsp_lane #(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          acc_en,
    input  logic [3:0]    fac,
    input  logic [DW-1:0] x_re,
    input  logic [DW-1:0] x_im,
    output logic [DW-1:0] y_re,
    output logic [DW-1:0] y_im
);
    localparam int PW = DW + 2;
    localparam int AW = DW + GW;
    localparam logic signed [AW-1:0] SAT_HI = AW'((1 << (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI;

    logic signed [PW-1:0] p_re, p_im;
    logic signed [AW-1:0] acc_re, acc_im;

    // Apply one coefficient code to a sample component, widened to PW bits.
    function automatic logic signed [PW-1:0] coef_term(input logic [1:0] c,
                                                        input logic [DW-1:0] v);
        logic signed [PW-1:0] ext;
        ext = {{(PW - DW){v[DW-1]}}, v};
        case (c)
            2'b01:   return ext;
            2'b11:   return -ext;
            default: return '0;
        endcase
    endfunction

    // Clamp a wide sum into the symmetric DW-bit range.
    function automatic logic [DW-1:0] clamp(input logic signed [AW-1:0] v);
        if (v > SAT_HI)      return SAT_HI[DW-1:0];
        else if (v < SAT_LO) return SAT_LO[DW-1:0];
        else                 return v[DW-1:0];
    endfunction

    // Short complex multiply: real and imaginary terms summed.
    always_comb begin
        p_re = coef_term(fac[1:0], x_re) - coef_term(fac[3:2], x_im);
        p_im = coef_term(fac[1:0], x_im) + coef_term(fac[3:2], x_re);
    end

    // Accumulators: clear at an accepted start, add on an accumulate cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (acc_en) begin
            acc_re <= acc_re + {{(AW - PW){p_re[PW-1]}}, p_re};
            acc_im <= acc_im + {{(AW - PW){p_im[PW-1]}}, p_im};
        end
    end

    // Saturated read-out.
    always_comb begin
        y_re = clamp(acc_re);
        y_im = clamp(acc_im);
    end
endmodule

// File: rtl/quad_despread_alu.sv
// Module: top of the four-lane complex despreading ALU. Latches the run
// configuration at start, holds the sample operands between samples and
// fans the operands out to the lanes. Assumes the code generators
// present one code set per sample, aligned with in_valid.
module quad_despread_alu
    import qdsp_pkg::*;
#(
    parameter int LANES = QD_LANES,
    parameter int DW    = QD_DW,
    parameter int GW    = QD_GW,
    parameter int LW    = QD_LW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LW-1:0]       start_len,
    input  logic [1:0]          start_mode,
    input  logic                start_clr,
    input  logic [LANES*4-1:0]  start_fac,
    input  logic                in_valid,
    input  logic [DW-1:0]       in_re,
    input  logic [DW-1:0]       in_im,
    input  logic [1:0]          scr_code,
    input  logic [LANES-1:0]    ovsf_code,
    output logic                busy,
    output logic                done,
    output logic [LANES*DW-1:0] out_re,
    output logic [LANES*DW-1:0] out_im
);
    localparam int CFW = 2 + LANES * QD_FW;
    localparam int OPW = LANES + 2 + 2 * DW;

    logic                 start_ok, take, acc_en;
    logic [CFW-1:0]       cfg_q;
    logic [OPW-1:0]       op_q;
    logic [1:0]           mode_q;
    logic [LANES*4-1:0]   field_q;
    logic [DW-1:0]        s_re, s_im;
    logic [1:0]           s_scr;
    logic [LANES-1:0]     s_spr;

    qdsp_ctrl #(.LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .in_valid(in_valid), .start_ok(start_ok), .take(take),
        .acc_en(acc_en), .busy(busy), .done(done)
    );

    // Run configuration, captured only on an accepted start.
    qdsp_opreg #(.W(CFW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(start_ok),
        .d({start_mode, start_fac}), .q(cfg_q)
    );

    // Sample operands, captured only when a sample is taken.
    qdsp_opreg #(.W(OPW)) u_ops (
        .clk(clk), .rst_n(rst_n), .en(take),
        .d({ovsf_code, scr_code, in_im, in_re}), .q(op_q)
    );

    // Unpack the held configuration and operands.
    always_comb begin
        {mode_q, field_q}           = cfg_q;
        {s_spr, s_scr, s_im, s_re}  = op_q;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [3:0] fac_k;

        qdsp_factor_sel u_sel (
            .mode(mode_q), .field(field_q[k*4 +: 4]), .scr(s_scr),
            .spread(s_spr[k]), .fac(fac_k)
        );

        qdsp_lane #(.DW(DW), .GW(GW)) u_lane (
            .clk(clk), .rst_n(rst_n), .clr(start_ok && start_clr),
            .acc_en(acc_en), .fac(fac_k), .x_re(s_re), .x_im(s_im),
            .y_re(out_re[k*DW +: DW]), .y_im(out_im[k*DW +: DW])
        );
    end
endmodule

// File: rtl/qdsp_chk.sv
// Module: assertion checker bound to the top. Watches the handshake,
// the done pulse, idle stability and the symmetric output range.
module qdsp_chk #(
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int LW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [LW-1:0]       start_len,
    input logic                busy,
    input logic                done,
    input logic [LANES*DW-1:0] out_re,
    input logic [LANES*DW-1:0] out_im
);
    // R10: done lasts a single cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: when done shows, the run has fully drained.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: done is always preceded by a busy cycle.
    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R9: an accepted start makes the block busy.
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && start_len != '0) |=> busy);

    // R12: idle with no valid start leaves the outputs untouched.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && start_len != '0)) |=> ($stable(out_re) && $stable(out_im)));

    for (genvar k = 0; k < LANES; k++) begin : g_rng
        // R8: the most negative code never appears on an output.
        a_r8_sym_re: assert property (@(posedge clk) disable iff (!rst_n)
            out_re[k*DW +: DW] != {1'b1, {(DW-1){1'b0}}});
        a_r8_sym_im: assert property (@(posedge clk) disable iff (!rst_n)
            out_im[k*DW +: DW] != {1'b1, {(DW-1){1'b0}}});
    end
endmodule

bind quad_despread_alu qdsp_chk #(.LANES(LANES), .DW(DW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .busy(busy), .done(done), .out_re(out_re), .out_im(out_im)
);

// File: tb/sim_quad_despread_alu.sv
`timescale 1ns/1ps
module sim_quad_despread_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  start_len;
    logic [1:0]  start_mode;
    logic        start_clr;
    logic [15:0] start_fac;
    logic        in_valid;
    logic [15:0] in_re, in_im;
    logic [1:0]  scr_code;
    logic [3:0]  ovsf_code;
    logic        busy, done;
    logic [63:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    int exp_re[4];
    int exp_im[4];

    always #2.5 clk = ~clk;

    quad_despread_alu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .start_mode(start_mode), .start_clr(start_clr), .start_fac(start_fac),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .scr_code(scr_code), .ovsf_code(ovsf_code),
        .busy(busy), .done(done), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int coef(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic int wrap24(input int v);
        logic [23:0] t;
        t = 24'(v);
        return int'($signed(t));
    endfunction

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32767) return -32767;
        return v;
    endfunction

    function automatic void lane_fac(input logic [1:0] mode, input logic [15:0] fac,
                                     input logic [1:0] scr, input logic [3:0] spr,
                                     input int k, output int a, output int b);
        int s;
        s = spr[k] ? -1 : 1;
        case (mode)
            2'b00: begin a = coef(fac[4*k +: 2]); b = coef(fac[4*k+2 +: 2]); end
            2'b01: begin a = scr[0] ? -1 : 1; b = scr[1] ? -1 : 1; end
            2'b10: begin a = s; b = 0; end
            default: begin a = (scr[0] ? -1 : 1) * s; b = (scr[1] ? -1 : 1) * s; end
        endcase
    endfunction

    task automatic check_outs(input string req);
        for (int k = 0; k < 4; k++) begin
            check(req, int'($signed(out_re[16*k +: 16])), sat16(exp_re[k]));
            check(req, int'($signed(out_im[16*k +: 16])), sat16(exp_im[k]));
        end
    endtask

    // kind 0: random data, 1: full-scale positive, 2: most negative.
    task automatic run_op(input string req, input logic [1:0] mode, input int len,
                          input logic clr, input logic [15:0] fac, input int kind,
                          input bit poke);
        int x, y, a, b;
        logic [15:0] r16;
        @(negedge clk);
        start = 1'b1; start_len = 8'(len); start_mode = mode;
        start_clr = clr; start_fac = fac; in_valid = 1'b0;
        if (clr) for (int k = 0; k < 4; k++) begin exp_re[k] = 0; exp_im[k] = 0; end
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", int'(busy), 1);
        for (int i = 0; i < len; i++) begin
            if (kind == 0 && ($urandom() % 4) == 0) begin
                in_valid = 1'b0;
                in_re = 16'($urandom());
                @(negedge clk);
            end
            case (kind)
                1: begin x = 32767; y = 32767; end
                2: begin x = -32768; y = -32768; end
                default: begin
                    r16 = 16'($urandom()); x = int'($signed(r16));
                    r16 = 16'($urandom()); y = int'($signed(r16));
                end
            endcase
            in_valid = 1'b1; in_re = 16'(x); in_im = 16'(y);
            scr_code = 2'($urandom()); ovsf_code = 4'($urandom());
            if (poke && i == len / 2) begin
                start = 1'b1; start_len = 8'd3; start_clr = 1'b1;
                start_mode = ~mode; start_fac = ~fac;
            end
            for (int k = 0; k < 4; k++) begin
                lane_fac(mode, fac, scr_code, ovsf_code, k, a, b);
                exp_re[k] = wrap24(exp_re[k] + a * x - b * y);
                exp_im[k] = wrap24(exp_im[k] + a * y + b * x);
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        check({req, " R10 no early done"}, int'(done), 0);
        check({req, " R9 busy through accumulate"}, int'(busy), 1);
        @(negedge clk);
        check({req, " R10 done pulse"}, int'(done), 1);
        check({req, " R10 idle at done"}, int'(busy), 0);
        check_outs(req);
        @(negedge clk);
        check({req, " R10 done one cycle"}, int'(done), 0);
        check({req, " R11 no restart"}, int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; start_len = '0; start_mode = '0; start_clr = 1'b0;
        start_fac = '0; in_valid = 1'b0; in_re = '0; in_im = '0; scr_code = '0; ovsf_code = '0;
        for (int k = 0; k < 4; k++) begin exp_re[k] = 0; exp_im[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset busy", int'(busy), 0);
        check("R10 reset done", int'(done), 0);
        check_outs("R7 reset zero");

        // R1 R2: +1, -1, +i, -i in the four lanes.
        run_op("R1 R2 field", 2'b00, 3, 1'b1, 16'hC431, 0, 1'b0);
        // R6: most negative sample through 1+i, -1-i, 1-i, -1+i.
        run_op("R6 extreme", 2'b00, 1, 1'b1, 16'h7DF5, 2, 1'b0);
        // R8: full-scale sums clamp symmetrically.
        run_op("R8 saturate", 2'b00, 10, 1'b1, 16'hF531, 1, 1'b0);
        // R7: 200 products of 65534 wrap the 24-bit accumulator negative.
        run_op("R7 wrap", 2'b00, 200, 1'b1, 16'hDDDD, 1, 1'b0);
        // R7: clear, then continue without clear.
        run_op("R7 clear", 2'b01, 5, 1'b1, 16'h0000, 0, 1'b0);
        run_op("R7 continue", 2'b11, 6, 1'b0, 16'h0000, 0, 1'b0);

        // Random runs in every source mode.
        for (int n = 0; n < 32; n++) begin
            logic [1:0] m;
            m = 2'(n);
            case (m)
                2'b00: run_op("R2 rand", m, 1 + int'($urandom() % 20), 1'b1, 16'($urandom()), 0, 1'b0);
                2'b01: run_op("R3 rand", m, 1 + int'($urandom() % 20), ($urandom() % 4) != 0, 16'($urandom()), 0, 1'b0);
                2'b10: run_op("R4 rand", m, 1 + int'($urandom() % 20), ($urandom() % 4) != 0, 16'($urandom()), 0, 1'b0);
                default: run_op("R5 rand", m, 1 + int'($urandom() % 20), ($urandom() % 4) != 0, 16'($urandom()), 0, 1'b0);
            endcase
        end

        // R11: a start issued mid-run is ignored.
        run_op("R11 start while busy", 2'b10, 8, 1'b1, 16'h0000, 0, 1'b1);

        // R11: a zero-length start with clear does nothing.
        @(negedge clk);
        start = 1'b1; start_len = 8'd0; start_clr = 1'b1; start_mode = 2'b00;
        @(negedge clk);
        start = 1'b0;
        check("R11 zero length busy", int'(busy), 0);
        @(negedge clk);
        check("R11 zero length done", int'(done), 0);
        check_outs("R11 zero length outputs");

        // R12: sample traffic while idle is ignored.
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_re = 16'($urandom()); in_im = 16'($urandom());
            scr_code = 2'($urandom()); ovsf_code = 4'($urandom());
            @(negedge clk);
            check("R12 idle done", int'(done), 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check_outs("R12 idle outputs");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule